// File: doc/BRIEF.md
# Serial-Chain Configuration Bank Loader

This block fills a small grid of configuration cells. The grid has columns, driven by bit lines, and rows, selected by word lines. Two serial shift chains feed the grid. One chain holds the column data and drives the bit lines. The other chain holds the row-select pattern and drives the word lines. Each chain has its own data input and its own shift strobe. A chain moves by one bit on each clock while its strobe is high.

A per-chain bit counter records when a chain is full. Once both chains are full, the loader runs a single write clock. During that clock the word-line pattern reaches the grid, and every cell on a selected row takes its column's bit-line value. Outside that clock the word lines are held low, so a half-shifted pattern can never reach the cells. A one-clock done pulse follows the write. The counters then clear, and the next frame can be shifted in. The cell grid is a register model, and its contents are exposed so they can be observed.

Top module: `sr_bank_loader`

## Requirements
- R1: While the column counter is below COLS, a high `bl_valid_i` on a clock edge shifts `bl_data_i` into bit 0 of `bl_o` and moves bit k to bit k+1. After COLS shifts, the first bit entered sits at bit COLS-1.
- R2: The row chain behaves the same way with `wl_data_i` and `wl_valid_i`, over ROWS bits. The chain contents appear on `wl_o` only during the write clock.
- R3: Once a chain has taken its full count of bits, further strobes for it are ignored until its counter clears after a write. Its contents stay unchanged.
- R4: `wl_o` is all zero in every clock except the write clock.
- R5: The write clock starts on the edge after the edge at which both chains become full. It lasts exactly one clock, and during it `wl_o` equals the row chain.
- R6: At the edge that ends the write clock, each cell (row r, column c) with `wl_o[r]`=1 takes `bl_o[c]`. Cells in rows with `wl_o[r]`=0 keep their value. Cell (r,c) appears at `cells_o[r*COLS+c]`.
- R7: `done_o` is high for exactly the one clock that follows the write clock. Both counters are zero after that edge.
- R8: Shift strobes that arrive during the write clock have no effect on either chain.
- R9: An asynchronous active-low `rst_ni` clears both chains, both counters, all cells and `done_o`, and holds `wl_o` at zero.
- R10: No cell changes at any edge that does not end a write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bl_data_i | input | 1 | Serial data for the column chain |
| bl_valid_i | input | 1 | Shift strobe for the column chain |
| wl_data_i | input | 1 | Serial data for the row chain |
| wl_valid_i | input | 1 | Shift strobe for the row chain |
| bl_o | output | COLS | Bit lines (column chain contents) |
| wl_o | output | ROWS | Word lines, gated to the write clock |
| done_o | output | 1 | One-clock pulse after each write |
| cells_o | output | ROWS*COLS | Cell grid contents, row-major |

## Verification
A wrong count in either chain shows up at the ports within a single clock. It either moves the write clock early or late, or lets an extra bit into `bl_o`. The bench sees this as a mismatch on `wl_o`, `bl_o` or `done_o` at the very next comparison. A write enable that leaks outside the write clock, or a wrong row or column mapping, corrupts `cells_o` on the edge where it happens. A per-clock comparison against a behavioural model pins each fault to the cycle that caused it. Frames are run with one row selected, several rows selected, all rows selected and no rows selected. They include extra strobes into a full chain and during the write, plus a reset in the middle of a load.

// File: rtl/sr_bank_pkg.sv
package sr_bank_pkg;
  typedef enum logic {
    LD_SHIFT = 1'b0,
    LD_WRITE = 1'b1
  } ld_state_e;
endpackage

// File: rtl/sr_shift_chain.sv
module sr_shift_chain #(
  parameter int unsigned LEN = 8,
  localparam int unsigned CW = $clog2(LEN + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_i,
  input  logic           data_i,
  input  logic           clr_i,
  output logic [LEN-1:0] q_o,
  output logic           full_o
);
  logic [LEN-1:0] q_q;
  logic [CW-1:0]  cnt_q;

  assign full_o = (cnt_q == CW'(LEN));
  assign q_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (shift_i && !full_o) begin
      if (LEN > 1) q_q <= {q_q[LEN-2:0], data_i};
      else         q_q <= LEN'(data_i);
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/sr_cell_array.sv
module sr_cell_array #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ROWS-1:0]      wl_i,
  input  logic [COLS-1:0]      bl_i,
  output logic [ROWS*COLS-1:0] cells_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      row_q <= '0;
      else if (wl_i[r]) row_q <= bl_i;
    end
    assign cells_o[r*COLS +: COLS] = row_q;
  end
endmodule

// File: rtl/sr_bank_loader.sv
module sr_bank_loader
  import sr_bank_pkg::*;
#(
  parameter int unsigned COLS = 8,
  parameter int unsigned ROWS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bl_data_i,
  input  logic                 bl_valid_i,
  input  logic                 wl_data_i,
  input  logic                 wl_valid_i,
  output logic [COLS-1:0]      bl_o,
  output logic [ROWS-1:0]      wl_o,
  output logic                 done_o,
  output logic [ROWS*COLS-1:0] cells_o
);
  ld_state_e       state_q;
  logic            bl_full, wl_full, write_en, done_q;
  logic [ROWS-1:0] wl_chain;

  assign write_en = (state_q == LD_WRITE);

  sr_shift_chain #(.LEN(COLS)) u_bl_chain (
    .clk_i, .rst_ni,
    .shift_i (bl_valid_i),
    .data_i  (bl_data_i),
    .clr_i   (write_en),
    .q_o     (bl_o),
    .full_o  (bl_full)
  );

  sr_shift_chain #(.LEN(ROWS)) u_wl_chain (
    .clk_i, .rst_ni,
    .shift_i (wl_valid_i),
    .data_i  (wl_data_i),
    .clr_i   (write_en),
    .q_o     (wl_chain),
    .full_o  (wl_full)
  );

  // word lines reach the grid only in the write clock
  assign wl_o = write_en ? wl_chain : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LD_SHIFT;
      done_q  <= 1'b0;
    end else begin
      done_q <= write_en;
      unique case (state_q)
        LD_SHIFT: if (bl_full && wl_full) state_q <= LD_WRITE;
        LD_WRITE: state_q <= LD_SHIFT;
        default:  state_q <= LD_SHIFT;
      endcase
    end
  end
  assign done_o = done_q;

  sr_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_cells (
    .clk_i, .rst_ni,
    .wl_i    (wl_o),
    .bl_i    (bl_o),
    .cells_o (cells_o)
  );
endmodule

// File: rtl/sr_bank_loader_chk.sv
module sr_bank_loader_chk #(
  parameter int unsigned COLS = 8,
  parameter int unsigned ROWS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bl_valid_i,
  input logic                 wl_valid_i,
  input logic [COLS-1:0]      bl_o,
  input logic [ROWS-1:0]      wl_o,
  input logic                 done_o,
  input logic [ROWS*COLS-1:0] cells_o
);
  AST_WL_SINGLE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wl_o != '0) |=> (wl_o == '0)); // R5
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wl_o != '0) |=> done_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_BL_FROZEN_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wl_o != '0) |=> $stable(bl_o)); // R8
  AST_CELLS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wl_o == '0) |=> $stable(cells_o)); // R10
  for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
    AST_ROW_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wl_o[r] |=> (cells_o[r*COLS +: COLS] == $past(bl_o))); // R6
    AST_ROW_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wl_o[r] |=> $stable(cells_o[r*COLS +: COLS])); // R6
  end
endmodule

bind sr_bank_loader sr_bank_loader_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk_i, .rst_ni, .bl_valid_i, .wl_valid_i,
  .bl_o, .wl_o, .done_o, .cells_o
);

// File: tb/test_sr_bank_loader.sv
module test_sr_bank_loader;
  localparam int unsigned COLS = 8;
  localparam int unsigned ROWS = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bl_data_i = 0, bl_valid_i = 0, wl_data_i = 0, wl_valid_i = 0;
  logic [COLS-1:0]      bl_o;
  logic [ROWS-1:0]      wl_o;
  logic                 done_o;
  logic [ROWS*COLS-1:0] cells_o;

  int errors = 0, checks = 0;

  // behavioural reference
  logic [COLS-1:0]      m_bl;
  logic [ROWS-1:0]      m_wl;
  int                   m_blc, m_wlc;
  bit                   m_wr, m_done;
  logic [ROWS*COLS-1:0] m_cells;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sr_bank_loader #(.COLS(COLS), .ROWS(ROWS)) i_sr_bank_loader (.*);

  task automatic model_reset();
    m_bl = '0; m_wl = '0; m_blc = 0; m_wlc = 0;
    m_wr = 0; m_done = 0; m_cells = '0;
  endtask

  task automatic model_edge(input logic bi, bv, wi, wv);
    if (m_wr) begin
      for (int r = 0; r < ROWS; r++)
        if (m_wl[r]) m_cells[r*COLS +: COLS] = m_bl;   // R6
      m_wr = 0; m_done = 1; m_blc = 0; m_wlc = 0;    // R7 R8
    end else begin
      m_done = 0;
      if (m_blc == COLS && m_wlc == ROWS) m_wr = 1;  // R5
      else begin
        if (bv && m_blc < COLS) begin m_bl = {m_bl[COLS-2:0], bi}; m_blc++; end // R1 R3
        if (wv && m_wlc < ROWS) begin m_wl = {m_wl[ROWS-2:0], wi}; m_wlc++; end // R2 R3
      end
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R1 R3 R8 bl_o", 64'(bl_o), 64'(m_bl));
    check("R2 R4 R5 wl_o", 64'(wl_o), 64'(m_wr ? m_wl : '0));
    check("R7 done_o", 64'(done_o), 64'(m_done));
    check("R6 R10 cells_o", 64'(cells_o), 64'(m_cells));
  endtask

  task automatic cyc(input logic bi, bv, wi, wv);
    bl_data_i = bi; bl_valid_i = bv; wl_data_i = wi; wl_valid_i = wv;
    @(posedge clk_i);
    model_edge(bi, bv, wi, wv);
    @(negedge clk_i);
    compare();
  endtask

  // shifts a frame in; junk keeps the strobes high past full and through the write
  task automatic load(input logic [COLS-1:0] bp, input logic [ROWS-1:0] wp, input bit junk);
    for (int i = 0; i < COLS; i++)
      cyc(bp[COLS-1-i], 1'b1,
          (i < ROWS) ? wp[ROWS-1-i] : 1'(i), (i < ROWS) || junk);
    for (int i = 0; i < 2; i++) cyc(1'(i), junk, ~1'(i), junk);
    for (int i = 0; i < 2; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk_i);
    compare();                       // R9 reset state
    @(negedge clk_i);
    rst_ni = 1'b1;
    load(8'hA5, 4'b0100, 1'b0);      // single row
    load(8'h3C, 4'b1001, 1'b1);      // two rows, extra strobes (R3 R8)
    load(8'hFF, 4'b1111, 1'b1);      // all rows
    load(8'h00, 4'b0000, 1'b0);      // no row: cells untouched (R10)
    load(8'h81, 4'b0010, 1'b1);
    // reset during a partial load (R9)
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1);
    rst_ni = 1'b0;
    #1;
    model_reset();
    check("R9 async wl_o", 64'(wl_o), 64'd0);
    check("R9 async cells_o", 64'(cells_o), 64'd0);
    @(negedge clk_i);
    compare();
    rst_ni = 1'b1;
    load(8'h5A, 4'b0001, 1'b0);
    load(8'hC3, 4'b0110, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule